// File: doc/BRIEF.md
# Local-Store DMA Command Engine

This engine serves one processing element whose loads and stores reach only its own private local memory. Data reaches or leaves that memory through the engine. The other side is a remote address space, which can be main memory or another element's local store. A command names a direction, a local byte address, a remote byte address and a byte count. A "get" pulls remote data into local memory. A "put" pushes local data out to the remote side.

Besides single-block commands, the engine runs a list command. This walks a table of block descriptors held in local memory. Each descriptor supplies its own remote address and byte count. The local address keeps advancing across the blocks, and one direction applies to the whole list. Data moves as 128-bit beats. Each beat is one read handshake on the source port followed by one write handshake on the destination port.

Only one command runs at a time. The engine reports completion with a one-cycle pulse and rejection with a one-cycle error pulse. A command offered while the engine is busy is dropped, and that drop is remembered in a sticky flag.

Top module: `lsdma_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `ovf`, `lm_req` and `rb_req` are all low.
- R2: A get (`cmd_put`=0) of N bytes does N/16 beats. Beat k reads the remote side at `cmd_raddr`+16k and then writes that same 128-bit word to local memory at `cmd_laddr`+16k.
- R3: A put (`cmd_put`=1) does the same, but it reads local memory and writes the remote side.
- R4: A single-block command whose `cmd_size` is above 16384 raises `err` on the cycle after it is offered. It makes no memory request and never raises `busy`. A size of exactly 16384 is accepted and moves 1024 beats.
- R5: A list command (`cmd_list`=1) whose `cmd_count` is below 2 or above 2048 is rejected in the same way as R4. Counts of 2 and 2048 are accepted.
- R6: List descriptor i sits in local memory at `cmd_lbase`+8i. Bits [31:0] of the descriptor hold the remote address and bits [63:32] hold the byte count. An even i sits in the low half of the 128-bit word and an odd i in the high half. Each descriptor is read with one local request. Its block starts at the local address where the previous block ended.
- R7: A local address, a list base, a single-block remote address or a single-block size whose low four bits are not zero causes rejection, as in R4.
- R8: A zero-size single command gives `done` one cycle after acceptance, with no memory request. A zero-size descriptor costs only its own fetch.
- R9: A command offered while `busy` is high is ignored and sets `ovf`. `ovf` then stays high until reset.
- R10: `done` is high for exactly one cycle, in the cycle after the final write handshake. `lm_req` and `rb_req` are never high together. A request holds its address until acknowledged.
- R11: A descriptor with a byte count above 16384, or with a misaligned count or address, ends the list. `err` pulses, `done` does not pulse, and no data request is made for that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_put | input | 1 | 1 = put (local to remote), 0 = get |
| cmd_list | input | 1 | 1 = list command |
| cmd_laddr | input | 16 | Local byte address of the data |
| cmd_raddr | input | 32 | Remote byte address (single mode) |
| cmd_size | input | 16 | Byte count (single mode) |
| cmd_count | input | 13 | Number of descriptors (list mode) |
| cmd_lbase | input | 16 | Local byte address of the descriptor table |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection or abort pulse |
| ovf | output | 1 | Sticky: a command arrived while busy |
| lm_req | output | 1 | Local memory request |
| lm_we | output | 1 | Local memory write enable |
| lm_addr | output | 16 | Local memory byte address |
| lm_wdata | output | 128 | Local memory write data |
| lm_ack | input | 1 | Local memory acknowledge |
| lm_rdata | input | 128 | Local memory read data, valid with ack |
| rb_req | output | 1 | Remote bus request |
| rb_we | output | 1 | Remote bus write enable |
| rb_addr | output | 32 | Remote byte address |
| rb_wdata | output | 128 | Remote write data |
| rb_ack | input | 1 | Remote bus acknowledge |
| rb_rdata | input | 128 | Remote read data, valid with ack |

## Verification
The hardest case to reach from the ports is a list that is well-formed and still breaks off in the middle. The outer command passes every check, so the abort depends on the content of a descriptor that the engine fetches for itself. The bench gets there by writing a table into its local memory model before issuing the list command. In that table the first descriptor carries an over-limit size. The bench then expects exactly one local fetch, an error pulse, and no data traffic.

A second hard case is the 2048-entry list. The bench builds it from zeroed descriptors, so the full count runs in a few thousand cycles with no data movement at all. A third is a command that lands while the engine is busy. The bench offers that command one cycle after a live transfer has started, and then checks that the destination region of the ignored command is untouched.

// File: rtl/lsdma_pkg.sv
package lsdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LFETCH = 3'd1,
      ST_READ   = 3'd2,
      ST_WRITE  = 3'd3,
      ST_DONE   = 3'd4
   } lsdma_state_e;

   localparam int DESC_W = 64;
   localparam int DESC_FIELD_W = 32;

endpackage

// File: rtl/lsdma_cmd_check.sv
module lsdma_cmd_check #(
   parameter int SIZE_W    = 16,
   parameter int CNT_W     = 13,
   parameter int ALIGN     = 4,
   parameter int MAX_BLOCK = 16384,
   parameter int LIST_MIN  = 2,
   parameter int LIST_MAX  = 2048
) (
   input  logic              is_list,
   input  logic [ALIGN-1:0]  laddr_lo,
   input  logic [ALIGN-1:0]  raddr_lo,
   input  logic [ALIGN-1:0]  lbase_lo,
   input  logic [SIZE_W-1:0] size,
   input  logic [CNT_W-1:0]  count,
   output logic              reject
);

   logic misaligned;
   logic bad_len;

   always_comb begin
      if (is_list) begin
         misaligned = (|laddr_lo) || (|lbase_lo);
         bad_len    = (count < CNT_W'(LIST_MIN)) || (count > CNT_W'(LIST_MAX));
      end else begin
         misaligned = (|laddr_lo) || (|raddr_lo) || (|size[ALIGN-1:0]);
         bad_len    = size > SIZE_W'(MAX_BLOCK);
      end
      reject = misaligned || bad_len;
   end

endmodule

// File: rtl/lsdma_desc_pick.sv
module lsdma_desc_pick
   import lsdma_pkg::*;
#(
   parameter int DATA_W = 128,
   localparam int SLOTS  = DATA_W / DESC_W,
   localparam int SEL_W  = $clog2(SLOTS)
) (
   input  logic [DATA_W-1:0]       beat,
   input  logic [SEL_W-1:0]        sel,
   output logic [DESC_FIELD_W-1:0] d_raddr,
   output logic [DESC_FIELD_W-1:0] d_size
);

   logic [DESC_W-1:0] slot [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign slot[g] = beat[g*DESC_W +: DESC_W];
   end

   assign d_raddr = slot[sel][DESC_FIELD_W-1:0];
   assign d_size  = slot[sel][DESC_W-1:DESC_FIELD_W];

endmodule

// File: rtl/lsdma_port_mux.sv
module lsdma_port_mux
   import lsdma_pkg::*;
#(
   parameter int LADDR_W = 16,
   parameter int RADDR_W = 32,
   parameter int DATA_W  = 128
) (
   input  lsdma_state_e       state,
   input  logic               put,
   input  logic [LADDR_W-1:0] laddr,
   input  logic [RADDR_W-1:0] raddr,
   input  logic [LADDR_W-1:0] fetch_addr,
   input  logic [DATA_W-1:0]  hold_data,
   input  logic               lm_ack,
   input  logic [DATA_W-1:0]  lm_rdata,
   input  logic               rb_ack,
   input  logic [DATA_W-1:0]  rb_rdata,
   output logic               lm_req,
   output logic               lm_we,
   output logic [LADDR_W-1:0] lm_addr,
   output logic [DATA_W-1:0]  lm_wdata,
   output logic               rb_req,
   output logic               rb_we,
   output logic [RADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0]  rb_wdata,
   output logic               src_ack,
   output logic [DATA_W-1:0]  src_rdata,
   output logic               dst_ack
);

   always_comb begin
      lm_req   = 1'b0;
      lm_we    = 1'b0;
      rb_req   = 1'b0;
      rb_we    = 1'b0;
      lm_addr  = laddr;
      rb_addr  = raddr;
      lm_wdata = hold_data;
      rb_wdata = hold_data;
      unique case (state)
         ST_LFETCH: begin
            lm_req  = 1'b1;
            lm_addr = fetch_addr;
         end
         ST_READ: begin
            if (put) lm_req = 1'b1;
            else     rb_req = 1'b1;
         end
         ST_WRITE: begin
            if (put) begin
               rb_req = 1'b1;
               rb_we  = 1'b1;
            end else begin
               lm_req = 1'b1;
               lm_we  = 1'b1;
            end
         end
         default: ;
      endcase
   end

   assign src_ack   = put ? lm_ack : rb_ack;
   assign src_rdata = put ? lm_rdata : rb_rdata;
   assign dst_ack   = put ? rb_ack : lm_ack;

endmodule

// File: rtl/lsdma_engine.sv
module lsdma_engine
   import lsdma_pkg::*;
#(
   parameter int LADDR_W   = 16,
   parameter int RADDR_W   = 32,
   parameter int DATA_W    = 128,
   parameter int MAX_BLOCK = 16384,
   parameter int LIST_MIN  = 2,
   parameter int LIST_MAX  = 2048,
   localparam int BEAT_B   = DATA_W / 8,
   localparam int ALIGN    = $clog2(BEAT_B),
   localparam int SIZE_W   = $clog2(MAX_BLOCK) + 2,
   localparam int CNT_W    = $clog2(LIST_MAX) + 2,
   localparam int SEL_W    = $clog2(DATA_W / DESC_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_put,
   input  logic               cmd_list,
   input  logic [LADDR_W-1:0] cmd_laddr,
   input  logic [RADDR_W-1:0] cmd_raddr,
   input  logic [SIZE_W-1:0]  cmd_size,
   input  logic [CNT_W-1:0]   cmd_count,
   input  logic [LADDR_W-1:0] cmd_lbase,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic               ovf,
   output logic               lm_req,
   output logic               lm_we,
   output logic [LADDR_W-1:0] lm_addr,
   output logic [DATA_W-1:0]  lm_wdata,
   input  logic               lm_ack,
   input  logic [DATA_W-1:0]  lm_rdata,
   output logic               rb_req,
   output logic               rb_we,
   output logic [RADDR_W-1:0] rb_addr,
   output logic [DATA_W-1:0]  rb_wdata,
   input  logic               rb_ack,
   input  logic [DATA_W-1:0]  rb_rdata
);

   if (DATA_W < 2 * DESC_W || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("lsdma_engine: DATA_W must be a power of two, at least 128");
   end
   if (MAX_BLOCK % BEAT_B != 0) begin : g_bad_block
      $error("lsdma_engine: MAX_BLOCK must be a whole number of beats");
   end
   if (LIST_MIN < 1 || LIST_MAX < LIST_MIN) begin : g_bad_list
      $error("lsdma_engine: list length bounds are inconsistent");
   end
   if (LADDR_W <= ALIGN || RADDR_W < ALIGN) begin : g_bad_addr
      $error("lsdma_engine: address widths too small for beat alignment");
   end

   lsdma_state_e       state;
   logic               put_q, list_q, err_q, ovf_q;
   logic [LADDR_W-1:0] laddr_q, lbase_q;
   logic [RADDR_W-1:0] raddr_q;
   logic [SIZE_W-1:0]  left_q;
   logic [CNT_W-1:0]   elems_left, elem_idx;
   logic [DATA_W-1:0]  data_q;

   logic                    reject;
   logic [DESC_FIELD_W-1:0] d_raddr, d_size;
   logic                    d_bad;
   logic [LADDR_W-1:0]      fetch_addr;
   logic                    src_ack, dst_ack;
   logic [DATA_W-1:0]       src_rdata;

   lsdma_cmd_check #(
      .SIZE_W(SIZE_W), .CNT_W(CNT_W), .ALIGN(ALIGN),
      .MAX_BLOCK(MAX_BLOCK), .LIST_MIN(LIST_MIN), .LIST_MAX(LIST_MAX)
   ) u_check (
      .is_list (cmd_list),
      .laddr_lo(cmd_laddr[ALIGN-1:0]),
      .raddr_lo(cmd_raddr[ALIGN-1:0]),
      .lbase_lo(cmd_lbase[ALIGN-1:0]),
      .size    (cmd_size),
      .count   (cmd_count),
      .reject  (reject)
   );

   lsdma_desc_pick #(.DATA_W(DATA_W)) u_pick (
      .beat   (lm_rdata),
      .sel    (elem_idx[SEL_W-1:0]),
      .d_raddr(d_raddr),
      .d_size (d_size)
   );

   assign d_bad = (d_size > DESC_FIELD_W'(MAX_BLOCK))
               || (|d_size[ALIGN-1:0]) || (|d_raddr[ALIGN-1:0]);
   assign fetch_addr = lbase_q + (LADDR_W'(elem_idx >> SEL_W) << ALIGN);

   lsdma_port_mux #(.LADDR_W(LADDR_W), .RADDR_W(RADDR_W), .DATA_W(DATA_W)) u_mux (
      .state     (state),
      .put       (put_q),
      .laddr     (laddr_q),
      .raddr     (raddr_q),
      .fetch_addr(fetch_addr),
      .hold_data (data_q),
      .lm_ack    (lm_ack),
      .lm_rdata  (lm_rdata),
      .rb_ack    (rb_ack),
      .rb_rdata  (rb_rdata),
      .lm_req    (lm_req),
      .lm_we     (lm_we),
      .lm_addr   (lm_addr),
      .lm_wdata  (lm_wdata),
      .rb_req    (rb_req),
      .rb_we     (rb_we),
      .rb_addr   (rb_addr),
      .rb_wdata  (rb_wdata),
      .src_ack   (src_ack),
      .src_rdata (src_rdata),
      .dst_ack   (dst_ack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         put_q      <= 1'b0;
         list_q     <= 1'b0;
         err_q      <= 1'b0;
         ovf_q      <= 1'b0;
         laddr_q    <= '0;
         lbase_q    <= '0;
         raddr_q    <= '0;
         left_q     <= '0;
         elems_left <= '0;
         elem_idx   <= '0;
         data_q     <= '0;
      end else begin
         err_q <= 1'b0;
         if (cmd_valid && state != ST_IDLE) ovf_q <= 1'b1;
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               put_q      <= cmd_put;
               list_q     <= cmd_list;
               laddr_q    <= cmd_laddr;
               raddr_q    <= cmd_raddr;
               left_q     <= cmd_size;
               elems_left <= cmd_count;
               elem_idx   <= '0;
               lbase_q    <= cmd_lbase;
               if (reject)               err_q <= 1'b1;
               else if (cmd_list)        state <= ST_LFETCH;
               else if (cmd_size == '0)  state <= ST_DONE;
               else                      state <= ST_READ;
            end
            ST_LFETCH: if (lm_ack) begin
               elems_left <= elems_left - 1'b1;
               elem_idx   <= elem_idx + 1'b1;
               raddr_q    <= RADDR_W'(d_raddr);
               left_q     <= SIZE_W'(d_size);
               if (d_bad) begin
                  state <= ST_IDLE;
                  err_q <= 1'b1;
               end else if (d_size == '0) begin
                  state <= (elems_left == CNT_W'(1)) ? ST_DONE : ST_LFETCH;
               end else begin
                  state <= ST_READ;
               end
            end
            ST_READ: if (src_ack) begin
               data_q <= src_rdata;
               state  <= ST_WRITE;
            end
            ST_WRITE: if (dst_ack) begin
               laddr_q <= laddr_q + LADDR_W'(BEAT_B);
               raddr_q <= raddr_q + RADDR_W'(BEAT_B);
               left_q  <= left_q - SIZE_W'(BEAT_B);
               if (left_q == SIZE_W'(BEAT_B))
                  state <= (list_q && elems_left != '0) ? ST_LFETCH : ST_DONE;
               else
                  state <= ST_READ;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_DONE);
   assign err  = err_q;
   assign ovf  = ovf_q;

endmodule

// File: rtl/lsdma_engine_chk.sv
module lsdma_engine_chk #(
   parameter int LADDR_W   = 16,
   parameter int RADDR_W   = 32,
   parameter int SIZE_W    = 16,
   parameter int MAX_BLOCK = 16384
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               cmd_list,
   input logic [SIZE_W-1:0]  cmd_size,
   input logic               busy,
   input logic               done,
   input logic               err,
   input logic               ovf,
   input logic               lm_req,
   input logic               lm_ack,
   input logic [LADDR_W-1:0] lm_addr,
   input logic               rb_req,
   input logic               rb_ack,
   input logic [RADDR_W-1:0] rb_addr
);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R9
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy) |=> ovf);

   // R10
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lm_req && rb_req));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   oversize_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !cmd_list && cmd_size > SIZE_W'(MAX_BLOCK)) |=> (err && !busy));

   // R10
   lm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lm_req && !lm_ack) |=> (lm_req && $stable(lm_addr)));

   // R10
   rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_req && !rb_ack) |=> (rb_req && $stable(rb_addr)));

endmodule

bind lsdma_engine lsdma_engine_chk #(
   .LADDR_W(LADDR_W), .RADDR_W(RADDR_W), .SIZE_W(SIZE_W), .MAX_BLOCK(MAX_BLOCK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_list (cmd_list),
   .cmd_size (cmd_size),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .ovf      (ovf),
   .lm_req   (lm_req),
   .lm_ack   (lm_ack),
   .lm_addr  (lm_addr),
   .rb_req   (rb_req),
   .rb_ack   (rb_ack),
   .rb_addr  (rb_addr)
);

// File: tb/tb_lsdma_engine.sv
module tb_lsdma_engine;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n;
   logic         cmd_valid, cmd_put, cmd_list;
   logic [15:0]  cmd_laddr, cmd_lbase;
   logic [31:0]  cmd_raddr;
   logic [15:0]  cmd_size;
   logic [12:0]  cmd_count;
   logic         busy, done, err, ovf;
   logic         lm_req, lm_we, lm_ack;
   logic [15:0]  lm_addr;
   logic [127:0] lm_wdata, lm_rdata;
   logic         rb_req, rb_we, rb_ack;
   logic [31:0]  rb_addr;
   logic [127:0] rb_wdata, rb_rdata;

   lsdma_engine dut (.*);

   logic [127:0] lmem [0:4095];
   logic [127:0] rmem [0:4095];
   int lm_hs, rb_hs;
   int total = 0;
   int bad   = 0;

   always @(posedge clk) begin
      if (lm_req && lm_ack) lm_hs++;
      if (rb_req && rb_ack) rb_hs++;
      if (!rst_n) begin
         lm_ack <= 1'b0;
         rb_ack <= 1'b0;
      end else begin
         if (lm_req && !lm_ack) begin
            lm_ack <= 1'b1;
            if (lm_we) lmem[lm_addr[15:4]] <= lm_wdata;
            else       lm_rdata <= lmem[lm_addr[15:4]];
         end else lm_ack <= 1'b0;
         if (rb_req && !rb_ack) begin
            rb_ack <= 1'b1;
            if (rb_we) rmem[rb_addr[15:4]] <= rb_wdata;
            else       rb_rdata <= rmem[rb_addr[15:4]];
         end else rb_ack <= 1'b0;
      end
   end

   function automatic logic [127:0] lpat(int i, int s);
      return {16'h1111, 16'(s), 32'(i), 32'h0bad0000 ^ 32'(s), ~32'(i)};
   endfunction
   function automatic logic [127:0] rpat(int i, int s);
      return {16'h2222, 16'(s), 32'(i), 32'h0ace0000 ^ 32'(s), ~32'(i)};
   endfunction

   task automatic fill(int s);
      for (int i = 0; i < 4096; i++) begin
         lmem[i] = lpat(i, s);
         rmem[i] = rpat(i, s);
      end
   endtask

   task automatic chk(string req, string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_cmd(input bit put, input bit lst, input logic [15:0] la,
                          input logic [31:0] ra, input logic [15:0] sz,
                          input logic [12:0] cnt, input logic [15:0] lb,
                          output int nd, output int ne);
      lm_hs = 0;
      rb_hs = 0;
      cmd_put = put; cmd_list = lst; cmd_laddr = la; cmd_raddr = ra;
      cmd_size = sz; cmd_count = cnt; cmd_lbase = lb; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      nd = 0;
      ne = 0;
      for (int i = 0; i < 20000; i++) begin
         if (done) nd++;
         if (err) ne++;
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   // put, laddr, raddr, size, expect_err
   localparam int NV = 7;
   localparam logic [65:0] VECS [0:NV-1] = '{
      {1'b0, 16'h0000, 32'h0000_1000, 16'h0040, 1'b0},
      {1'b1, 16'h0200, 32'h0000_2000, 16'h0100, 1'b0},
      {1'b0, 16'h0000, 32'h0000_0000, 16'h4000, 1'b0},
      {1'b1, 16'h0000, 32'h0000_0000, 16'h4010, 1'b1},
      {1'b0, 16'h0008, 32'h0000_0000, 16'h0010, 1'b1},
      {1'b1, 16'h0000, 32'h0000_0000, 16'h0018, 1'b1},
      {1'b1, 16'h1230, 32'h0000_5FF0, 16'h0010, 1'b0}
   };

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      bad++;
      total++;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int nd, ne, miss;
      rst_n = 1'b0;
      cmd_valid = 1'b0; cmd_put = 1'b0; cmd_list = 1'b0;
      cmd_laddr = '0; cmd_raddr = '0; cmd_size = '0; cmd_count = '0; cmd_lbase = '0;
      lm_rdata = '0; rb_rdata = '0;
      fill(0);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "err", err, 0);
      chk("R1", "ovf", ovf, 0);
      chk("R1", "lm_req", lm_req, 0);
      chk("R1", "rb_req", rb_req, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic        vput, verr;
         logic [15:0] vla, vsz;
         logic [31:0] vra;
         int beats, li, ri;
         string tag;
         {vput, vla, vra, vsz, verr} = VECS[v];
         if (verr) tag = (vsz > 16'h4000) ? "R4" : "R7";
         else      tag = vput ? "R3" : "R2";
         fill(v + 1);
         run_cmd(vput, 1'b0, vla, vra, vsz, '0, '0, nd, ne);
         beats = verr ? 0 : int'(vsz) / 16;
         li = int'(vla[15:4]);
         ri = int'(vra[15:4]);
         chk(tag, $sformatf("vec %0d err pulses", v), ne, verr ? 1 : 0);
         chk(tag, $sformatf("vec %0d done pulses", v), nd, verr ? 0 : 1);
         chk(tag, $sformatf("vec %0d local handshakes", v), lm_hs, beats);
         chk(tag, $sformatf("vec %0d remote handshakes", v), rb_hs, beats);
         miss = 0;
         for (int k = 0; k < beats; k++) begin
            if (vput ? (rmem[ri+k] != lmem[li+k]) : (lmem[li+k] != rmem[ri+k])) miss++;
         end
         chk(tag, $sformatf("vec %0d mismatched beats", v), miss, 0);
         chk(tag, $sformatf("vec %0d word past end untouched", v),
             vput ? (rmem[ri+beats] == rpat(ri+beats, v+1)) : (lmem[li+beats] == lpat(li+beats, v+1)), 1);
      end

      // R8 zero-size single command
      fill(30);
      run_cmd(1'b0, 1'b0, 16'h0000, 32'h0, 16'h0000, '0, '0, nd, ne);
      chk("R8", "zero single done", nd, 1);
      chk("R8", "zero single err", ne, 0);
      chk("R8", "zero single traffic", lm_hs + rb_hs, 0);

      // R6 list get with a zero-size middle descriptor (R8)
      fill(20);
      lmem[3000] = {32'h0, 32'h0000_0800, 32'h40, 32'h0000_0100};
      lmem[3001] = {64'h0, 32'h20, 32'h0000_2000};
      run_cmd(1'b0, 1'b1, 16'h0400, 32'h0, 16'h0, 13'd3, 16'hBB80, nd, ne);
      chk("R6", "list get done", nd, 1);
      chk("R6", "list get err", ne, 0);
      chk("R6", "list get local handshakes", lm_hs, 9);
      chk("R8", "list get remote handshakes (zero descriptor skipped)", rb_hs, 6);
      miss = 0;
      for (int k = 0; k < 4; k++) if (lmem[16'h40+k] != rmem[16'h10+k]) miss++;
      if (lmem[16'h44] != rmem[16'h200]) miss++;
      if (lmem[16'h45] != rmem[16'h201]) miss++;
      chk("R6", "list get mismatched beats", miss, 0);
      chk("R6", "list get word past end", lmem[16'h46] == lpat(16'h46, 20), 1);

      // R6 list put
      fill(21);
      lmem[3000] = {32'h10, 32'h0000_3400, 32'h30, 32'h0000_3000};
      run_cmd(1'b1, 1'b1, 16'h0100, 32'h0, 16'h0, 13'd2, 16'hBB80, nd, ne);
      chk("R6", "list put done", nd, 1);
      chk("R6", "list put local handshakes", lm_hs, 6);
      chk("R6", "list put remote handshakes", rb_hs, 4);
      miss = 0;
      for (int k = 0; k < 3; k++) if (rmem[16'h300+k] != lmem[16'h10+k]) miss++;
      if (rmem[16'h340] != lmem[16'h13]) miss++;
      chk("R6", "list put mismatched beats", miss, 0);

      // R11 oversize descriptor aborts the list
      fill(22);
      lmem[3000] = {32'h10, 32'h0, 32'h4010, 32'h0};
      run_cmd(1'b0, 1'b1, 16'h0000, 32'h0, 16'h0, 13'd2, 16'hBB80, nd, ne);
      chk("R11", "abort err", ne, 1);
      chk("R11", "abort done", nd, 0);
      chk("R11", "abort local handshakes", lm_hs, 1);
      chk("R11", "abort remote handshakes", rb_hs, 0);
      chk("R11", "abort local data untouched", lmem[0] == lpat(0, 22), 1);

      // R5 list length bounds
      run_cmd(1'b0, 1'b1, 16'h0000, 32'h0, 16'h0, 13'd1, 16'hBB80, nd, ne);
      chk("R5", "count 1 err", ne, 1);
      chk("R5", "count 1 traffic", lm_hs + rb_hs + nd, 0);
      run_cmd(1'b0, 1'b1, 16'h0000, 32'h0, 16'h0, 13'd2049, 16'hBB80, nd, ne);
      chk("R5", "count 2049 err", ne, 1);
      chk("R5", "count 2049 traffic", lm_hs + rb_hs + nd, 0);
      fill(23);
      for (int i = 1024; i < 2048; i++) lmem[i] = '0;
      run_cmd(1'b1, 1'b1, 16'h0000, 32'h0, 16'h0, 13'd2048, 16'h4000, nd, ne);
      chk("R5", "count 2048 done", nd, 1);
      chk("R5", "count 2048 err", ne, 0);
      chk("R5", "count 2048 descriptor fetches", lm_hs, 2048);
      chk("R8", "count 2048 zero descriptors, remote traffic", rb_hs, 0);

      // R9 command while busy is dropped and flagged
      fill(24);
      chk("R9", "ovf before overlap", ovf, 0);
      lm_hs = 0;
      rb_hs = 0;
      cmd_put = 1'b0; cmd_list = 1'b0; cmd_laddr = 16'h0000; cmd_raddr = 32'h1000;
      cmd_size = 16'h0100; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_laddr = 16'h0800; cmd_raddr = 32'h3000;
      @(negedge clk);
      cmd_valid = 1'b0;
      nd = 0;
      for (int i = 0; i < 2000; i++) begin
         if (done) nd++;
         if (!busy) break;
         @(negedge clk);
      end
      chk("R9", "ovf after overlap", ovf, 1);
      chk("R10", "one done pulse for overlapped run", nd, 1);
      chk("R9", "remote handshakes of first command only", rb_hs, 16);
      chk("R9", "dropped command target untouched", lmem[16'h80] == lpat(16'h80, 24), 1);
      miss = 0;
      for (int k = 0; k < 16; k++) if (lmem[k] != rmem[16'h100+k]) miss++;
      chk("R9", "first command data", miss, 0);
      run_cmd(1'b0, 1'b0, 16'h0000, 32'h0, 16'h0000, '0, '0, nd, ne);
      chk("R9", "ovf stays set", ovf, 1);
      chk("R10", "done width on zero command", nd, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule